// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps wall-clock time as six BCD digits: hours, minutes and seconds, two digits each, in 12-hour form. Every register runs on one system clock. A millisecond strobe input is counted by a divider. Each time the divider completes one second, it makes a single-cycle advance enable. A user step pulse gives the same advance. The pulse is one cycle wide and is already synchronised to the clock by logic outside this block.

An advance increments the seconds units digit, and carries ripple upward through the other digits in the same clock edge. The hour field runs from 1 to 12 and then wraps to 1; it never shows 0. A flash output inverts on every advance, so a display can blink a separator at the rate the time moves. An asynchronous active-low reset loads 12:00:00.

Top module: `tod12_counter`

## Requirements
- R1: While reset is low, and after it is released with no advance, the outputs read 1,2 : 0,0 : 0,0 (hours tens, hours units, minutes tens, minutes units, seconds tens, seconds units), and the flash output is 0.
- R2: On each advance, the seconds units digit steps up by one from 0 to 9. From 9 it returns to 0 and sends a carry to the seconds tens digit.
- R3: The seconds tens digit counts 0 to 5 on carries. From 5 it returns to 0 and carries into the minutes units digit.
- R4: The minutes units digit wraps from 9 to 0 and the minutes tens digit wraps from 5 to 0, each passing a carry upward; the carry out of the minutes tens digit goes to the hours.
- R5: The hours always read between 01 and 12. When the hours read 12 and a carry arrives, they become 01. When the hours read 01 to 08 or 10 to 11, a carry increments the hours units digit.
- R6: When the hours read 09 and a carry arrives, the hours become 10: the units digit clears and the tens digit becomes 1.
- R7: The flash output inverts on the clock edge of every advance and holds its value otherwise.
- R8: A second advance happens on the edge where the MS_PER_SEC-th millisecond strobe since the previous second advance (or since reset) is sampled. User steps do not change the strobe count.
- R9: A user step pulse advances the time exactly like a second advance. With neither a step nor a completed second, every output holds.
- R10: When a second advance and a user step fall in the same cycle, the time advances by one step only, and the flash output inverts once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, loads 12:00:00 |
| ms_strobe | input | 1 | One-cycle pulse once per millisecond |
| user_step | input | 1 | Synchronised one-cycle request to advance the time by one step |
| hr_tens | output | 4 | Hours tens digit (0 or 1) |
| hr_units | output | 4 | Hours units digit |
| min_tens | output | 4 | Minutes tens digit |
| min_units | output | 4 | Minutes units digit |
| sec_tens | output | 4 | Seconds tens digit |
| sec_units | output | 4 | Seconds units digit |
| flash | output | 1 | Inverts on every advance |

## Verification
The bench walks the clock through a full twelve-hour cycle, checking each wrap as it passes.
- If the 12-to-1 wrap were wrong, the bench would see the time land on 00 or 13.
- If the 09-to-10 step were wrong, it would see 0A or 00.
- If a digit's limit were wrong, a minute would show 60, or a carry would be missing or late.

Strobes are also lined up so that the completing millisecond and a user step land in the same cycle. A design that added the two would skip a second, and its flash output would fail to toggle. Separate checks confirm three more things:
- user steps leave the millisecond count untouched;
- MS_PER_SEC-1 strobes do not advance the time;
- the time holds when nothing is requested.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam int BCD_W = 4;
   typedef logic [BCD_W-1:0] bcd_t;
   localparam bcd_t HR_TENS_RST  = 4'd1;
   localparam bcd_t HR_UNITS_RST = 4'd2;
endpackage

// File: rtl/tod_sec_divider.sv
module tod_sec_divider #(
   parameter int MS_PER_SEC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ms_strobe,
   output logic sec_tick
);
   localparam int CW   = (MS_PER_SEC > 2) ? $clog2(MS_PER_SEC) : 1;
   localparam int LAST = MS_PER_SEC - 1;

   generate
      if (MS_PER_SEC < 2) begin : g_bad_param
         $error("MS_PER_SEC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] ms_cnt;
   logic          at_last;

   assign at_last  = (ms_cnt == CW'(LAST));
   assign sec_tick = ms_strobe && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ms_cnt <= '0;
      else if (ms_strobe)
         ms_cnt <= at_last ? '0 : ms_cnt + 1'b1;
   end

   p_cnt_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ms_cnt <= CW'(LAST));
   p_cnt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_strobe |=> $stable(ms_cnt));
endmodule

// File: rtl/tod_bcd_digit.sv
module tod_bcd_digit
   import tod_pkg::*;
#(
   parameter int MAX_VAL = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   output bcd_t value,
   output logic carry
);
   generate
      if (MAX_VAL < 1 || MAX_VAL > 9) begin : g_bad_param
         $error("MAX_VAL must lie in 1..9");
      end
   endgenerate

   logic at_max;
   assign at_max = (value == bcd_t'(MAX_VAL));
   assign carry  = inc && at_max;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= '0;
      else if (inc)
         value <= at_max ? '0 : value + 1'b1;
   end

   p_digit_wraps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && value == bcd_t'(MAX_VAL)) |=> value == '0);
   p_digit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      value <= bcd_t'(MAX_VAL));
endmodule

// File: rtl/tod_hour_pair.sv
module tod_hour_pair
   import tod_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   output bcd_t tens,
   output bcd_t units
);
   logic at_twelve, at_nine;
   assign at_twelve = (tens == 4'd1) && (units == 4'd2);
   assign at_nine   = (units == 4'd9);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tens  <= HR_TENS_RST;
         units <= HR_UNITS_RST;
      end else if (inc) begin
         if (at_twelve) begin
            tens  <= 4'd0;
            units <= 4'd1;
         end else if (at_nine) begin
            tens  <= 4'd1;
            units <= 4'd0;
         end else begin
            units <= units + 1'b1;
         end
      end
   end

   p_hour_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tens == 4'd0 && units != 4'd0 && units <= 4'd9) ||
      (tens == 4'd1 && units <= 4'd2));
   p_twelve_to_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && tens == 4'd1 && units == 4'd2) |=> (tens == 4'd0 && units == 4'd1));
   p_nine_to_ten_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && tens == 4'd0 && units == 4'd9) |=> (tens == 4'd1 && units == 4'd0));
endmodule

// File: rtl/tod12_counter.sv
module tod12_counter
   import tod_pkg::*;
#(
   parameter int MS_PER_SEC = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ms_strobe,
   input  logic       user_step,
   output logic [3:0] hr_tens,
   output logic [3:0] hr_units,
   output logic [3:0] min_tens,
   output logic [3:0] min_units,
   output logic [3:0] sec_tens,
   output logic [3:0] sec_units,
   output logic       flash
);
   localparam int N_LOW = 4;

   logic             sec_tick;
   logic             advance;
   logic [N_LOW:0]   chain;
   bcd_t             digit [N_LOW];

   tod_sec_divider #(.MS_PER_SEC(MS_PER_SEC)) u_div (
      .clk(clk), .rst_n(rst_n), .ms_strobe(ms_strobe), .sec_tick(sec_tick));

   assign advance  = sec_tick | user_step;
   assign chain[0] = advance;

   genvar gi;
   generate
      for (gi = 0; gi < N_LOW; gi++) begin : g_digit
         localparam int LIM = (gi % 2 == 0) ? 9 : 5;
         tod_bcd_digit #(.MAX_VAL(LIM)) u_dig (
            .clk(clk), .rst_n(rst_n), .inc(chain[gi]),
            .value(digit[gi]), .carry(chain[gi+1]));
      end
   endgenerate

   tod_hour_pair u_hours (
      .clk(clk), .rst_n(rst_n), .inc(chain[N_LOW]),
      .tens(hr_tens), .units(hr_units));

   assign sec_units = digit[0];
   assign sec_tens  = digit[1];
   assign min_units = digit[2];
   assign min_tens  = digit[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flash <= 1'b0;
      else if (advance)
         flash <= ~flash;
   end

   p_flash_toggles_r7: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> flash != $past(flash));
   p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(sec_units) && $stable(flash) && $stable(hr_units));
   p_single_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && sec_units != 4'd9) |=> sec_units == $past(sec_units) + 4'd1);
   p_sec_units_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && sec_units == 4'd9) |=> sec_units == 4'd0);
   p_sec_tens_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tens <= 4'd5);
endmodule

// File: tb/tb_tod12_counter.sv
`timescale 1ns/1ps
module tb_tod12_counter;
   localparam int MS = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ms_strobe = 1'b0;
   logic user_step = 1'b0;
   logic [3:0] hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units;
   logic flash;

   tod12_counter #(.MS_PER_SEC(MS)) dut (
      .clk(clk), .rst_n(rst_n), .ms_strobe(ms_strobe), .user_step(user_step),
      .hr_tens(hr_tens), .hr_units(hr_units), .min_tens(min_tens),
      .min_units(min_units), .sec_tens(sec_tens), .sec_units(sec_units),
      .flash(flash));

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int m_h = 12, m_m = 0, m_s = 0, m_ms = 0, m_prev_h = 12;
   bit m_fl = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_h = 12; m_m = 0; m_s = 0; m_ms = 0; m_fl = 1'b0; m_prev_h = 12;
      end else begin
         bit tick;
         tick = 1'b0;
         m_prev_h = m_h;
         if (ms_strobe) begin
            m_ms = m_ms + 1;
            if (m_ms == MS) begin m_ms = 0; tick = 1'b1; end
         end
         if (tick || user_step) begin
            m_fl = ~m_fl;
            m_s = m_s + 1;
            if (m_s == 60) begin
               m_s = 0; m_m = m_m + 1;
               if (m_m == 60) begin
                  m_m = 0;
                  m_h = (m_h == 12) ? 1 : m_h + 1;
               end
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(sec_units == 4'(m_s % 10), "R2 sec_units", sec_units, m_s % 10);
         check(sec_tens == 4'(m_s / 10), "R3 sec_tens", sec_tens, m_s / 10);
         check(min_units == 4'(m_m % 10), "R4 min_units", min_units, m_m % 10);
         check(min_tens == 4'(m_m / 10), "R4 min_tens", min_tens, m_m / 10);
         check(hr_units == 4'(m_h % 10), "R5 hr_units", hr_units, m_h % 10);
         check(hr_tens == 4'(m_h / 10), "R5 hr_tens", hr_tens, m_h / 10);
         check(flash == m_fl, "R7 flash", flash, m_fl);
         if (m_prev_h == 9 && m_h == 10)
            check(hr_tens == 4'd1 && hr_units == 4'd0, "R6 nine_to_ten",
                  hr_tens * 10 + hr_units, 10);
      end
   end

   task automatic cyc(input bit strobe, input bit step);
      ms_strobe = strobe;
      user_step = step;
      @(posedge clk); #1;
      ms_strobe = 1'b0;
      user_step = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int s0;
      bit f0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state while held low
      check({hr_tens, hr_units, min_tens, min_units, sec_tens, sec_units} == 24'h120000,
            "R1 reset", {hr_tens, hr_units}, 8'h12);
      check(flash == 1'b0, "R1 flash_reset", flash, 0);
      rst_n = 1'b1;
      repeat (3) cyc(1'b0, 1'b0);
      check(hr_tens == 1 && hr_units == 2 && sec_units == 0, "R1 after_release",
            sec_units, 0);

      // R8: MS-1 strobes hold, the MS-th advances
      repeat (MS - 1) cyc(1'b1, 1'b0);
      check(sec_units == 0, "R8 before_last_strobe", sec_units, 0);
      cyc(1'b1, 1'b0);
      check(sec_units == 1, "R8 last_strobe", sec_units, 1);

      // R8/R9: user steps do not disturb the strobe count
      repeat (MS - 1) cyc(1'b1, 1'b0);
      repeat (3) cyc(1'b0, 1'b1);
      check(sec_units == 4, "R9 user_step", sec_units, 4);
      cyc(1'b1, 1'b0);
      check(sec_units == 5, "R8 count_kept", sec_units, 5);

      // R9: idle holds
      f0 = flash;
      repeat (7) cyc(1'b0, 1'b0);
      check(sec_units == 5 && flash == f0, "R9 idle_hold", sec_units, 5);

      // R10: coincident tick and step
      repeat (MS - 1) cyc(1'b1, 1'b0);
      s0 = sec_units; f0 = flash;
      cyc(1'b1, 1'b1);
      check(sec_units == 4'(s0 + 1), "R10 single_advance", sec_units, s0 + 1);
      check(flash == ~f0, "R10 flash_once", flash, ~f0);

      // Full twelve-hour walk with steps, strobes sprinkled in
      for (int i = 0; i < 43200; i++) begin
         cyc((i % 3) == 0, 1'b1);
      end
      repeat (20) cyc(1'b1, 1'b0);

      // R5: wrap 12 -> 01 directed
      while (!(m_h == 12 && m_m == 59 && m_s == 59)) cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b1);
      check(hr_tens == 0 && hr_units == 1, "R5 twelve_to_one",
            hr_tens * 10 + hr_units, 1);

      repeat (2) cyc(1'b0, 1'b0);
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule